// File: doc/BRIEF.md
# Modified-Line Bitmap Tracker

This block lives inside an I/O device whose memory the host maps with caching enabled. During a phase it keeps one flag per 64-byte line of a tracked window. A flag is raised when anything modifies that line. The modification can come from the device's own logic, from a host full-line write-combined burst, or from a small uncached host store. A single observation port carries all of these writes.

At the end of a phase the host issues a phase-end command. On that clock edge the live map is frozen into a snapshot register and the live map starts again from empty. The host then reads the snapshot as a set of 64-bit words. It invalidates only the lines whose bits are set and keeps the rest of its cached copy. The map for the default 512 lines is exactly one 64-byte line. It is read as eight words in ascending order.

Writes that fall outside the window mark nothing. They raise a sticky out-of-range flag, which the next phase-end clears.

Top module: `dirty_line_map`

## Requirements
- R1: A write whose bytes all lie in one line sets only that line's bit, where the line index is the byte address divided by 64.
- R2: wr_size encodes the write length: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 8 bytes, and 4 to 7 = 64 bytes. The length need not be aligned.
- R3: A set bit stays set through any number of later writes until the next phase-end. Writing the same line again changes nothing.
- R4: A write whose last byte falls in the line after its first byte sets both line bits. A single write never sets more than two bits.
- R5: On a phase-end cycle the snapshot takes the live map as it stood before that edge, and the live map is cleared. A write in the same cycle lands in the new live map only. The snapshot changes on no other cycle.
- R6: When rd_en is high with rd_word = k, rd_data shows snapshot bits 64k+63 down to 64k on the next cycle, so map bit n is bit n%64 of word n/64. While rd_en is low, rd_data holds its value.
- R7: A line with index of LINES or more is never marked, although the in-range line of a straddling write is still marked. Such a write sets oor_flag on the next cycle. The flag stays set until a phase-end clears it, except that an out-of-range write in the phase-end cycle sets it again.
- R8: Reset clears the live map, the snapshot, rd_data and oor_flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | A write is observed this cycle |
| wr_addr | input | ADDR_W | Byte address of the write's first byte, relative to the window base |
| wr_size | input | 3 | Length code of the write (R2) |
| phase_end | input | 1 | Snapshot the live map and start a new phase |
| rd_en | input | 1 | Load one snapshot word into rd_data |
| rd_word | input | $clog2(LINES/WORD_W) | Index of the snapshot word to read |
| rd_data | output | WORD_W | Registered snapshot word |
| oor_flag | output | 1 | Sticky flag for a write outside the window |

## Verification
The assertions check the following on every cycle:
- Live bits never drop between phase-ends.
- The snapshot moves only on a phase-end, and then it equals the prior live map.
- A decoded write marks at most two bits, and they are adjacent.
- rd_data holds, or reflects the selected snapshot word.
- The out-of-range flag persists.

Only the bench's scenarios can show that specific addresses and length codes map to the right line numbers at the right word and bit positions. The same holds for the phase-end cycle that also carries a write, for the flag being re-armed by an out-of-range write at phase-end, and for the cleared state after a mid-run reset.

// File: rtl/dlm_pkg.sv
package dlm_pkg;

  // log2 of the tracked line size in bytes
  localparam int unsigned LINE_SHIFT = 6;

  // Length code of an observed write, in bytes (R2)
  function automatic logic [6:0] size_bytes(input logic [2:0] code);
    case (code)
      3'd0:    return 7'd1;
      3'd1:    return 7'd2;
      3'd2:    return 7'd4;
      3'd3:    return 7'd8;
      default: return 7'd64;
    endcase
  endfunction

endpackage

// File: rtl/dlm_wr_decode.sv
module dlm_wr_decode #(
  parameter int ADDR_W = 20,
  parameter int LINES  = 512
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_valid,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [2:0]               wr_size,
  output logic                     a_vld,
  output logic [$clog2(LINES)-1:0] a_idx,
  output logic                     b_vld,
  output logic [$clog2(LINES)-1:0] b_idx,
  output logic                     oor_hit
);
  import dlm_pkg::*;

  localparam int IDX_W  = $clog2(LINES);
  localparam int LINE_W = ADDR_W - LINE_SHIFT;

  logic [ADDR_W:0] last_byte;
  logic [LINE_W:0] first_ln;
  logic [LINE_W:0] last_ln;
  logic            first_in;
  logic            last_in;
  logic            spans;

  always_comb begin
    last_byte = {1'b0, wr_addr} + {{(ADDR_W-6){1'b0}}, size_bytes(wr_size)}
                - (ADDR_W+1)'(1);
    first_ln  = {1'b0, wr_addr[ADDR_W-1:LINE_SHIFT]};
    last_ln   = last_byte[ADDR_W:LINE_SHIFT];
    first_in  = first_ln < (LINE_W+1)'(LINES);
    last_in   = last_ln  < (LINE_W+1)'(LINES);
    spans     = last_ln != first_ln;
    a_vld     = wr_valid && first_in;
    a_idx     = first_ln[IDX_W-1:0];
    b_vld     = wr_valid && spans && last_in;
    b_idx     = last_ln[IDX_W-1:0];
    oor_hit   = wr_valid && (!first_in || (spans && !last_in));
  end

  // R4: a second mark always belongs to the line right after the first
  p_pair_adjacent_r4: assert property (@(posedge clk) disable iff (!rst_n)
    b_vld |-> (a_vld && (b_idx == a_idx + IDX_W'(1))));

endmodule

// File: rtl/dlm_map_store.sv
module dlm_map_store #(
  parameter int LINES = 512
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     a_vld,
  input  logic [$clog2(LINES)-1:0] a_idx,
  input  logic                     b_vld,
  input  logic [$clog2(LINES)-1:0] b_idx,
  input  logic                     phase_end,
  output logic [LINES-1:0]         snap
);
  localparam int IDX_W = $clog2(LINES);

  logic [LINES-1:0] set_vec;
  logic [LINES-1:0] live_d, live_q;
  logic [LINES-1:0] snap_q;

  for (genvar i = 0; i < LINES; i++) begin : g_bit
    assign set_vec[i] = (a_vld && (a_idx == IDX_W'(i))) ||
                        (b_vld && (b_idx == IDX_W'(i)));
  end

  // next state of the live map: clear on phase end, then merge this cycle's marks
  always_comb begin
    live_d = phase_end ? '0 : live_q;
    live_d = live_d | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live_q <= '0;
    else        live_q <= live_d;
  end

  // snapshot register, enabled by the phase-end command only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         snap_q <= '0;
    else if (phase_end) snap_q <= live_q;
  end

  assign snap = snap_q;

  // R3: live bits only accumulate within a phase
  p_bits_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !phase_end |=> ((live_q & $past(live_q)) == $past(live_q)));

  // R4: one write marks at most two lines
  p_at_most_two_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(set_vec) <= 2);

  // R5: phase end freezes the pre-edge live map
  p_snap_take_r5: assert property (@(posedge clk) disable iff (!rst_n)
    phase_end |=> (snap_q == $past(live_q)));

  // R5: snapshot holds between phase ends
  p_snap_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !phase_end |=> $stable(snap_q));

endmodule

// File: rtl/dirty_line_map.sv
module dirty_line_map #(
  parameter int ADDR_W = 20,
  parameter int LINES  = 512,
  parameter int WORD_W = 64
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_valid,
  input  logic [ADDR_W-1:0]                 wr_addr,
  input  logic [2:0]                        wr_size,
  input  logic                              phase_end,
  input  logic                              rd_en,
  input  logic [$clog2(LINES/WORD_W)-1:0]   rd_word,
  output logic [WORD_W-1:0]                 rd_data,
  output logic                              oor_flag
);
  localparam int IDX_W  = $clog2(LINES);
  localparam int NWORDS = LINES / WORD_W;

  logic             a_vld, b_vld, oor_hit;
  logic [IDX_W-1:0] a_idx, b_idx;
  logic [LINES-1:0] snap;
  logic [WORD_W-1:0] words [NWORDS];
  logic [WORD_W-1:0] rd_d, rd_q;
  logic             oor_d, oor_q;

  dlm_wr_decode #(.ADDR_W(ADDR_W), .LINES(LINES)) u_decode (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_size(wr_size),
    .a_vld(a_vld), .a_idx(a_idx), .b_vld(b_vld), .b_idx(b_idx),
    .oor_hit(oor_hit)
  );

  dlm_map_store #(.LINES(LINES)) u_store (
    .clk(clk), .rst_n(rst_n),
    .a_vld(a_vld), .a_idx(a_idx), .b_vld(b_vld), .b_idx(b_idx),
    .phase_end(phase_end), .snap(snap)
  );

  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    assign words[w] = snap[w*WORD_W +: WORD_W];
  end

  always_comb begin
    rd_d  = rd_en ? words[rd_word] : rd_q;
    oor_d = (phase_end ? 1'b0 : oor_q) | oor_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      oor_q <= 1'b0;
    end else begin
      rd_q  <= rd_d;
      oor_q <= oor_d;
    end
  end

  assign rd_data  = rd_q;
  assign oor_flag = oor_q;

  // R6: registered word follows the selected snapshot word
  p_rd_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> (rd_q == $past(words[rd_word])));

  // R6: output holds without a read
  p_rd_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_q));

  // R7: the flag persists until a phase end
  p_oor_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (oor_q && !phase_end) |=> oor_q);

endmodule

// File: tb/dirty_line_map_tb_top.sv
`timescale 1ns/1ps
module dirty_line_map_tb_top;

  localparam int ADDR_W = 20;
  localparam int LINES  = 512;
  localparam int WORD_W = 64;
  localparam int NWORDS = LINES / WORD_W;
  localparam int NONE   = -1;

  typedef struct packed {
    logic [19:0] addr;
    logic [2:0]  size;
    int          exp_a;
    int          exp_b;
    logic        exp_oor;
  } vec_t;

  localparam int NVEC = 12;
  localparam vec_t VECS [NVEC] = '{
    '{20'h00000, 3'd0,   0, NONE, 1'b0},  // 1 byte, line 0
    '{20'h0007F, 3'd1,   1,    2, 1'b0},  // 2 bytes across lines 1/2
    '{20'h0013C, 3'd2,   4, NONE, 1'b0},  // 4 bytes ending at line edge
    '{20'h0013E, 3'd2,   4,    5, 1'b0},  // 4 bytes across lines 4/5
    '{20'h01000, 3'd4,  64, NONE, 1'b0},  // aligned full line
    '{20'h01020, 3'd7,  64,   65, 1'b0},  // misaligned 64 bytes
    '{20'h07FF8, 3'd3, 511, NONE, 1'b0},  // last 8 bytes of window
    '{20'h07FFC, 3'd3, 511, NONE, 1'b1},  // straddles window end
    '{20'h08000, 3'd0, NONE, NONE, 1'b1}, // first byte past window
    '{20'hFFFC0, 3'd5, NONE, NONE, 1'b1}, // far outside
    '{20'h03FC0, 3'd3, 255, NONE, 1'b0},  // word 3 bit 63
    '{20'h02001, 3'd6, 128,  129, 1'b0}   // misaligned 64 bytes
  };

  logic                    clk;
  logic                    rst_n;
  logic                    wr_valid;
  logic [ADDR_W-1:0]       wr_addr;
  logic [2:0]              wr_size;
  logic                    phase_end;
  logic                    rd_en;
  logic [2:0]              rd_word;
  logic [WORD_W-1:0]       rd_data;
  logic                    oor_flag;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  dirty_line_map #(.ADDR_W(ADDR_W), .LINES(LINES), .WORD_W(WORD_W)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_size(wr_size),
    .phase_end(phase_end), .rd_en(rd_en), .rd_word(rd_word),
    .rd_data(rd_data), .oor_flag(oor_flag)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk_map(input string req, input logic [LINES-1:0] act,
                         input logic [LINES-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s map actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_val(input string req, input logic [WORD_W-1:0] act,
                         input logic [WORD_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one cycle of stimulus, driven at the falling edge
  task automatic step(input logic we, input logic [ADDR_W-1:0] a,
                      input logic [2:0] s, input logic pe);
    wr_valid = we; wr_addr = a; wr_size = s; phase_end = pe;
    @(negedge clk);
    wr_valid = 1'b0; phase_end = 1'b0;
  endtask

  task automatic read_map(output logic [LINES-1:0] m);
    m = '0;
    for (int k = 0; k < NWORDS; k++) begin
      rd_en = 1'b1; rd_word = 3'(k);
      @(negedge clk);
      m[k*WORD_W +: WORD_W] = rd_data;
    end
    rd_en = 1'b0;
  endtask

  function automatic logic [LINES-1:0] lines2(input int a, input int b);
    logic [LINES-1:0] m = '0;
    if (a >= 0) m[a] = 1'b1;
    if (b >= 0) m[b] = 1'b1;
    return m;
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog R8 actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [LINES-1:0] m;
    rst_n = 1'b0; wr_valid = 1'b0; wr_addr = '0; wr_size = '0;
    phase_end = 1'b0; rd_en = 1'b0; rd_word = '0;
    repeat (3) @(negedge clk);
    // R8: reset state
    chk_val("R8 oor_flag in reset", 64'(oor_flag), 64'd0);
    chk_val("R8 rd_data in reset", rd_data, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    read_map(m);
    chk_map("R8 snapshot after reset", m, '0);

    // vector table: R1 R2 R4 R7
    for (int v = 0; v < NVEC; v++) begin
      step(1'b1, VECS[v].addr, VECS[v].size, 1'b0);
      chk_val($sformatf("R7 oor_flag vector %0d", v), 64'(oor_flag),
              64'(VECS[v].exp_oor));
      step(1'b0, '0, '0, 1'b1);
      chk_val($sformatf("R7 oor_flag cleared vector %0d", v), 64'(oor_flag), 64'd0);
      read_map(m);
      chk_map($sformatf("R1 R2 R4 vector %0d", v), m,
              lines2(VECS[v].exp_a, VECS[v].exp_b));
    end

    // R3: accumulation and repeated writes
    step(1'b1, 20'd192, 3'd0, 1'b0);
    step(1'b1, 20'd197, 3'd3, 1'b0);
    step(1'b1, 20'd19200, 3'd4, 1'b0);
    step(1'b0, '0, '0, 1'b1);
    read_map(m);
    chk_map("R3 accumulated lines 3 and 300", m, lines2(3, 300));
    step(1'b0, '0, '0, 1'b1);
    read_map(m);
    chk_map("R5 live map cleared by phase end", m, '0);

    // R5: write in the phase-end cycle goes to the new phase
    step(1'b1, 20'd640, 3'd0, 1'b0);
    step(1'b1, 20'd1280, 3'd0, 1'b1);
    read_map(m);
    chk_map("R5 snapshot excludes same-cycle write", m, lines2(10, NONE));
    step(1'b0, '0, '0, 1'b1);
    read_map(m);
    chk_map("R5 same-cycle write in next phase", m, lines2(20, NONE));

    // R7: out-of-range write in the phase-end cycle re-arms the flag
    step(1'b1, 20'h09000, 3'd0, 1'b0);
    step(1'b1, 20'h09000, 3'd0, 1'b1);
    chk_val("R7 flag re-armed at phase end", 64'(oor_flag), 64'd1);
    step(1'b0, '0, '0, 1'b0);
    chk_val("R7 flag sticky", 64'(oor_flag), 64'd1);
    step(1'b0, '0, '0, 1'b1);
    chk_val("R7 flag cleared", 64'(oor_flag), 64'd0);

    // R6: rd_data holds without rd_en
    step(1'b1, 20'h07FC0, 3'd4, 1'b0);
    step(1'b0, '0, '0, 1'b1);
    read_map(m);
    chk_map("R6 line 511 in word 7", m, lines2(511, NONE));
    rd_word = 3'd0;
    @(negedge clk);
    chk_val("R6 rd_data holds", rd_data, 64'h8000_0000_0000_0000);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    chk_val("R6 word 0 read", rd_data, 64'd0);

    // R8: mid-run reset
    step(1'b1, 20'h0A000, 3'd0, 1'b0);
    step(1'b1, 20'd64, 3'd0, 1'b1);
    rst_n = 1'b0;
    @(negedge clk);
    chk_val("R8 oor_flag after mid-run reset", 64'(oor_flag), 64'd0);
    chk_val("R8 rd_data after mid-run reset", rd_data, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    read_map(m);
    chk_map("R8 snapshot after mid-run reset", m, '0);
    step(1'b0, '0, '0, 1'b1);
    read_map(m);
    chk_map("R8 live map after mid-run reset", m, '0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule